// File: doc/BRIEF.md
# Nonvolatile Memory Power and Busy Controller

This block sits between the core and an on-chip Flash/EEPROM array. It follows write and erase activity reported by the array sequencer and the core's low-power requests (wait-for-interrupt, halt, stop). From these it decides when the array may drop into standby or power-down. A low-power request that arrives while a write is still running is held until that write has finished.

The block drives a read-only busy flag. While the flag is high, read data presented to the core is replaced by all-ones and core writes never reach the array. The flag is forced high for a programmable number of cycles after power-up reset and after waking from power-down, so that the array has time to settle before it is first read. Both delays are parameters counted in clock cycles.

Top module: `nvm_pwr_busy_ctrl`

## Requirements
- R1: The state output is encoded READ=0, WRITE=1, PEND_LP=2, STANDBY=3, POWERDOWN=4, RECOVER=5, and it never takes any other value. In READ, a wait-for-interrupt request moves the state on the next edge: to STANDBY when `wfi_deep_sel` is 0, or to POWERDOWN when it is 1. In STANDBY, `rd_data` equals `arr_rdata`.
- R2: A low-power request seen in WRITE moves the state to PEND_LP. The state stays in PEND_LP until `wr_done` or `erase_susp`. On that edge it enters the requested low-power state and busy drops.
- R3: A halt or stop request always selects POWERDOWN, whatever `wfi_deep_sel` is. During a write it is deferred through PEND_LP in the same way as R2.
- R4: A `wr_start` in READ enters WRITE on the next edge. `wr_kind` is encoded 0 = Flash program, 1 = EEPROM page update, 2 = chip erase, 3 = sector erase. Busy rises on that edge for kind 1, and for kind 2 when `ee_wmode_sel` is 1. Every other combination leaves busy at 0.
- R5: In WRITE, `wr_done` or `erase_susp` returns the state to READ on the next edge, with busy at 0.
- R6: While busy is 1, every byte lane of `rd_data` is FFh and `arr_wr_en` is 0. In READ with busy at 0, `rd_data` equals `arr_rdata` and `arr_wr_en` follows `cpu_wr_req`.
- R7: During reset the state is RECOVER and busy is 1. The state stays RECOVER for PUP_READY_CYC rising edges after reset is released, and it becomes READ on edge PUP_READY_CYC+1.
- R8: In POWERDOWN, busy is 1 and the state holds until `wake`. After the edge that accepts `wake`, the state is RECOVER with busy 1 for PD_WAKE_CYC further edges, and it becomes READ on the edge after those.
- R10: A `wake` in STANDBY returns the state to READ on the next edge. A `wake` in READ has no effect.
- R11: A low-power request wins over a `wr_start` in the same cycle, both in READ and in PEND_LP when the cycle also carries `wr_done`. In that case the write is ignored: the state goes to low power and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| wfi_req | input | 1 | Wait-for-interrupt request pulse |
| halt_req | input | 1 | Halt request pulse |
| stop_req | input | 1 | Stop request pulse |
| wfi_deep_sel | input | 1 | 0: wait-for-interrupt goes to standby, 1: to power-down |
| wr_start | input | 1 | Sequencer began a write or erase |
| wr_kind | input | 2 | Kind of operation started (see R4) |
| ee_wmode_sel | input | 1 | EEPROM write-mode select, qualifies chip erase |
| wr_done | input | 1 | Sequencer finished the operation |
| erase_susp | input | 1 | Sequencer suspended a sector erase |
| wake | input | 1 | Interrupt wake event |
| arr_rdata | input | DATA_W | Raw read data from the array |
| cpu_wr_req | input | 1 | Core write strobe toward the array |
| rd_data | output | DATA_W | Read data to the core, all-ones while blocked |
| arr_wr_en | output | 1 | Write enable passed to the array |
| pwr_state | output | 3 | Controller state (encoding in R1) |
| busy | output | 1 | Read-only busy flag |

## Verification
The checker checks the following on every clock:
- busy is always high in RECOVER;
- reads and writes are always blocked while busy;
- PEND_LP and POWERDOWN hold until their release events;
- the one-edge exits from STANDBY and POWERDOWN on `wake`;
- the state stays within its six codes.

Only the directed scenarios can show:
- the exact lengths of the power-up and wake-up windows;
- the per-kind busy decision;
- the choice between standby and power-down;
- the priority of a low-power request over a simultaneous write start.

// File: rtl/nvm_pb_pkg.sv
package nvm_pb_pkg;

   typedef enum logic [2:0] {
      ST_READ  = 3'd0,
      ST_WRITE = 3'd1,
      ST_PEND  = 3'd2,
      ST_STBY  = 3'd3,
      ST_PDOWN = 3'd4,
      ST_RECOV = 3'd5
   } pb_state_e;

   typedef enum logic [1:0] {
      WK_FLASH = 2'd0,
      WK_PAGE  = 2'd1,
      WK_CHIP  = 2'd2,
      WK_SECT  = 2'd3
   } wr_kind_e;

   localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/nvm_pb_lpreq.sv
// Folds the three core low-power requests into "any request" and
// "request needs power-down".
module nvm_pb_lpreq (
   input  logic wfi_req,
   input  logic halt_req,
   input  logic stop_req,
   input  logic wfi_deep_sel,
   output logic lp_any,
   output logic lp_deep
);
   always_comb begin
      lp_any  = wfi_req | halt_req | stop_req;
      lp_deep = halt_req | stop_req | (wfi_req & wfi_deep_sel);
   end
endmodule

// File: rtl/nvm_pb_timer.sv
// Ready-window countdown. It is preloaded for the power-up window at
// reset and reloaded for the wake window when power-down is left.
module nvm_pb_timer #(
   parameter int unsigned PUP_CYC = 40,
   parameter int unsigned PDW_CYC = 12,
   localparam int unsigned MAXC   = (PUP_CYC > PDW_CYC) ? PUP_CYC : PDW_CYC,
   localparam int unsigned CW     = $clog2(MAXC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_pd,
   input  logic run,
   output logic expired
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CW'(PUP_CYC);
      end else if (load_pd) begin
         cnt_q <= CW'(PDW_CYC);
      end else if (run && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvm_pb_fsm.sv
module nvm_pb_fsm
   import nvm_pb_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lp_any,
   input  logic      lp_deep,
   input  logic      wr_start,
   input  logic [1:0] wr_kind,
   input  logic      ee_wmode_sel,
   input  logic      wr_done,
   input  logic      erase_susp,
   input  logic      wake,
   input  logic      tmr_expired,
   output pb_state_e state,
   output logic      wr_busy,
   output logic      tmr_load_pd
);
   pb_state_e state_q, state_d;
   logic      deep_q, deep_d;
   logic      busy_q, busy_d;
   logic      wr_end;
   logic      busy_set;

   assign wr_end   = wr_done | erase_susp;
   assign busy_set = (wr_kind == WK_PAGE) | ((wr_kind == WK_CHIP) & ee_wmode_sel);

   always_comb begin
      state_d     = state_q;
      deep_d      = deep_q;
      busy_d      = busy_q;
      tmr_load_pd = 1'b0;
      unique case (state_q)
         ST_READ: begin
            if (lp_any) begin
               // low power wins over a write start in the same cycle
               state_d = lp_deep ? ST_PDOWN : ST_STBY;
            end else if (wr_start) begin
               state_d = ST_WRITE;
               busy_d  = busy_set;
            end
         end
         ST_WRITE: begin
            if (wr_end) begin
               busy_d  = 1'b0;
               state_d = lp_any ? (lp_deep ? ST_PDOWN : ST_STBY) : ST_READ;
            end else if (lp_any) begin
               state_d = ST_PEND;
               deep_d  = lp_deep;
            end
         end
         ST_PEND: begin
            deep_d = deep_q | lp_deep;
            if (wr_end) begin
               busy_d  = 1'b0;
               state_d = (deep_q | lp_deep) ? ST_PDOWN : ST_STBY;
            end
         end
         ST_STBY: begin
            if (wake) state_d = ST_READ;
         end
         ST_PDOWN: begin
            if (wake) begin
               state_d     = ST_RECOV;
               tmr_load_pd = 1'b1;
            end
         end
         ST_RECOV: begin
            if (tmr_expired) state_d = ST_READ;
         end
         default: state_d = ST_RECOV;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RECOV;
         deep_q  <= 1'b0;
         busy_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         deep_q  <= deep_d;
         busy_q  <= busy_d;
      end
   end

   assign state   = state_q;
   assign wr_busy = busy_q;
endmodule

// File: rtl/nvm_pb_gate.sv
// Blocks core access to the array: reads are forced to all-ones per
// byte lane while access is blocked; the write strobe passes only in
// READ with no busy condition.
module nvm_pb_gate
   import nvm_pb_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned LANES = DATA_W / LANE_W
) (
   input  pb_state_e          state,
   input  logic               busy,
   input  logic [DATA_W-1:0]  arr_rdata,
   input  logic               cpu_wr_req,
   output logic [DATA_W-1:0]  rd_data,
   output logic               arr_wr_en
);
   logic rd_block;

   assign rd_block  = busy | (state == ST_PDOWN) | (state == ST_RECOV);
   assign arr_wr_en = cpu_wr_req & (state == ST_READ) & ~busy;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign rd_data[l*LANE_W +: LANE_W] =
         rd_block ? {LANE_W{1'b1}} : arr_rdata[l*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/nvm_pwr_busy_ctrl.sv
module nvm_pwr_busy_ctrl
   import nvm_pb_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned PUP_READY_CYC = 40,
   parameter int unsigned PD_WAKE_CYC   = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wfi_req,
   input  logic              halt_req,
   input  logic              stop_req,
   input  logic              wfi_deep_sel,
   input  logic              wr_start,
   input  logic [1:0]        wr_kind,
   input  logic              ee_wmode_sel,
   input  logic              wr_done,
   input  logic              erase_susp,
   input  logic              wake,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic              cpu_wr_req,
   output logic [DATA_W-1:0] rd_data,
   output logic              arr_wr_en,
   output logic [2:0]        pwr_state,
   output logic              busy
);
   if ((DATA_W < LANE_W) || ((DATA_W % LANE_W) != 0)) begin : g_bad_width
      $error("DATA_W must be a nonzero multiple of 8");
   end
   if (PUP_READY_CYC < 1) begin : g_bad_pup
      $error("PUP_READY_CYC must be at least 1");
   end
   if (PD_WAKE_CYC < 1) begin : g_bad_pdw
      $error("PD_WAKE_CYC must be at least 1");
   end

   logic      lp_any, lp_deep;
   logic      tmr_expired, tmr_load_pd;
   logic      wr_busy;
   pb_state_e st;

   nvm_pb_lpreq u_lpreq (
      .wfi_req      (wfi_req),
      .halt_req     (halt_req),
      .stop_req     (stop_req),
      .wfi_deep_sel (wfi_deep_sel),
      .lp_any       (lp_any),
      .lp_deep      (lp_deep)
   );

   nvm_pb_timer #(
      .PUP_CYC (PUP_READY_CYC),
      .PDW_CYC (PD_WAKE_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_pd (tmr_load_pd),
      .run     (st == ST_RECOV),
      .expired (tmr_expired)
   );

   nvm_pb_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .lp_any       (lp_any),
      .lp_deep      (lp_deep),
      .wr_start     (wr_start),
      .wr_kind      (wr_kind),
      .ee_wmode_sel (ee_wmode_sel),
      .wr_done      (wr_done),
      .erase_susp   (erase_susp),
      .wake         (wake),
      .tmr_expired  (tmr_expired),
      .state        (st),
      .wr_busy      (wr_busy),
      .tmr_load_pd  (tmr_load_pd)
   );

   assign busy      = wr_busy | (st == ST_PDOWN) | (st == ST_RECOV);
   assign pwr_state = st;

   nvm_pb_gate #(.DATA_W(DATA_W)) u_gate (
      .state      (st),
      .busy       (busy),
      .arr_rdata  (arr_rdata),
      .cpu_wr_req (cpu_wr_req),
      .rd_data    (rd_data),
      .arr_wr_en  (arr_wr_en)
   );
endmodule

// File: rtl/nvm_pb_chk.sv
module nvm_pb_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wake,
   input logic              wr_done,
   input logic              erase_susp,
   input logic              busy,
   input logic              arr_wr_en,
   input logic [2:0]        pwr_state,
   input logic [DATA_W-1:0] rd_data
);
   assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_state <= 3'd5);

   assert_pend_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd2 && !wr_done && !erase_susp) |=> pwr_state == 3'd2);

   assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!arr_wr_en && rd_data == {DATA_W{1'b1}}));

   assert_recover_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd5) |-> busy);

   assert_pdown_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd4 && !wake) |=> pwr_state == 3'd4);

   assert_pdown_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd4 && wake) |=> pwr_state == 3'd5);

   assert_stby_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 3'd3 && wake) |=> pwr_state == 3'd0);
endmodule

bind nvm_pwr_busy_ctrl nvm_pb_chk #(.DATA_W(DATA_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .wake       (wake),
   .wr_done    (wr_done),
   .erase_susp (erase_susp),
   .busy       (busy),
   .arr_wr_en  (arr_wr_en),
   .pwr_state  (pwr_state),
   .rd_data    (rd_data)
);

// File: tb/nvm_pwr_busy_ctrl_tb_top.sv
module nvm_pwr_busy_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW  = 16;
   localparam int PUP = 16;
   localparam int PDW = 5;
   localparam logic [DW-1:0] ONES = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wfi_req = 0, halt_req = 0, stop_req = 0, wfi_deep_sel = 0;
   logic wr_start = 0, ee_wmode_sel = 0, wr_done = 0, erase_susp = 0, wake = 0;
   logic [1:0] wr_kind = 2'd0;
   logic [DW-1:0] arr_rdata = '0;
   logic cpu_wr_req = 0;
   logic [DW-1:0] rd_data;
   logic arr_wr_en, busy;
   logic [2:0] pwr_state;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nvm_pwr_busy_ctrl #(
      .DATA_W(DW), .PUP_READY_CYC(PUP), .PD_WAKE_CYC(PDW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .halt_req(halt_req),
      .stop_req(stop_req), .wfi_deep_sel(wfi_deep_sel), .wr_start(wr_start),
      .wr_kind(wr_kind), .ee_wmode_sel(ee_wmode_sel), .wr_done(wr_done),
      .erase_susp(erase_susp), .wake(wake), .arr_rdata(arr_rdata),
      .cpu_wr_req(cpu_wr_req), .rd_data(rd_data), .arr_wr_en(arr_wr_en),
      .pwr_state(pwr_state), .busy(busy)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic clear_pulses();
      wfi_req = 0; halt_req = 0; stop_req = 0; wr_start = 0;
      wr_done = 0; erase_susp = 0; wake = 0;
   endtask

   task automatic start_write(input logic [1:0] kind, input logic wm);
      wr_start = 1; wr_kind = kind; ee_wmode_sel = wm;
      step(); clear_pulses();
   endtask

   task automatic finish_write();
      wr_done = 1; step(); clear_pulses();
   endtask

   task automatic wake_out_of_pdown(input string tag);
      wake = 1; step(); clear_pulses();
      chk({tag, " R8 recover after wake"}, pwr_state, 5);
      repeat (PDW) step();
      chk({tag, " R8 still recover at window end"}, pwr_state, 5);
      chk({tag, " R8 busy in window"}, busy, 1);
      step();
      chk({tag, " R8 read after window"}, pwr_state, 0);
      chk({tag, " R8 busy released"}, busy, 0);
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (3) step();
      chk("R7 reset state", pwr_state, 5);
      chk("R7 reset busy", busy, 1);
      chk("R6 reset read blocked", rd_data, ONES);
      rst_n = 1;
      repeat (PUP) step();
      chk("R7 recover held to window end", pwr_state, 5);
      chk("R7 busy held to window end", busy, 1);
      step();
      chk("R7 read after window", pwr_state, 0);
      chk("R7 busy clear after window", busy, 0);
   endtask

   task automatic t_read_write();
      arr_rdata = 16'h5AC3; cpu_wr_req = 1; #1;
      chk("R6 read passes in READ", rd_data, 16'h5AC3);
      chk("R6 write passes in READ", arr_wr_en, 1);
      cpu_wr_req = 0; #1;
      chk("R6 write enable follows strobe", arr_wr_en, 0);
   endtask

   task automatic t_page();
      start_write(2'd1, 1'b0);
      chk("R4 page update state", pwr_state, 1);
      chk("R4 page update busy", busy, 1);
      arr_rdata = 16'h1234; cpu_wr_req = 1; #1;
      chk("R6 read forced while busy", rd_data, ONES);
      chk("R6 write dropped while busy", arr_wr_en, 0);
      cpu_wr_req = 0;
      finish_write();
      chk("R5 done returns to read", pwr_state, 0);
      chk("R5 done clears busy", busy, 0);
   endtask

   task automatic t_kinds();
      start_write(2'd0, 1'b1);
      chk("R4 flash program state", pwr_state, 1);
      chk("R4 flash program not busy", busy, 0);
      finish_write();
      start_write(2'd2, 1'b0);
      chk("R4 chip erase mode0 not busy", busy, 0);
      finish_write();
      start_write(2'd2, 1'b1);
      chk("R4 chip erase mode1 busy", busy, 1);
      finish_write();
      start_write(2'd3, 1'b1);
      chk("R4 sector erase not busy", busy, 0);
      finish_write();
      chk("R5 back to read", pwr_state, 0);
   endtask

   task automatic t_susp();
      start_write(2'd1, 1'b0);
      erase_susp = 1; step(); clear_pulses();
      chk("R5 suspend returns to read", pwr_state, 0);
      chk("R5 suspend clears busy", busy, 0);
   endtask

   task automatic t_wfi_pend();
      start_write(2'd1, 1'b0);
      wfi_deep_sel = 0; wfi_req = 1; step(); clear_pulses();
      chk("R2 pending after wfi in write", pwr_state, 2);
      repeat (3) step();
      chk("R2 pending held", pwr_state, 2);
      chk("R2 busy during pending", busy, 1);
      finish_write();
      chk("R2 R1 standby after write end", pwr_state, 3);
      chk("R2 busy clear in standby", busy, 0);
      arr_rdata = 16'hABCD; #1;
      chk("R1 standby read passes", rd_data, 16'hABCD);
      wake = 1; step(); clear_pulses();
      chk("R10 wake standby to read", pwr_state, 0);
      wake = 1; step(); clear_pulses();
      chk("R10 wake in read no effect", pwr_state, 0);
   endtask

   task automatic t_wfi_deep();
      wfi_deep_sel = 1; wfi_req = 1; step(); clear_pulses();
      chk("R1 wfi deep to powerdown", pwr_state, 4);
      chk("R8 busy in powerdown", busy, 1);
      arr_rdata = 16'h0F0F; #1;
      chk("R8 read blocked in powerdown", rd_data, ONES);
      step();
      chk("R8 powerdown held", pwr_state, 4);
      wake_out_of_pdown("wfi");
      wfi_deep_sel = 0;
   endtask

   task automatic t_halt_stop();
      wfi_deep_sel = 0; halt_req = 1; step(); clear_pulses();
      chk("R3 halt to powerdown", pwr_state, 4);
      wake_out_of_pdown("halt");
      start_write(2'd1, 1'b0);
      stop_req = 1; step(); clear_pulses();
      chk("R3 stop deferred in write", pwr_state, 2);
      finish_write();
      chk("R3 stop to powerdown after write", pwr_state, 4);
      wake_out_of_pdown("stop");
   endtask

   task automatic t_prio();
      wfi_deep_sel = 0; wfi_req = 1; wr_start = 1; wr_kind = 2'd1;
      step(); clear_pulses();
      chk("R11 lowpower wins in read", pwr_state, 3);
      chk("R11 write ignored no busy", busy, 0);
      wake = 1; step(); clear_pulses();
      start_write(2'd1, 1'b0);
      wfi_req = 1; step(); clear_pulses();
      chk("R11 pending", pwr_state, 2);
      wr_done = 1; wr_start = 1; wr_kind = 2'd1; step(); clear_pulses();
      chk("R11 lowpower wins in pending", pwr_state, 3);
      chk("R11 second write ignored", busy, 0);
      wake = 1; step(); clear_pulses();
      chk("R10 read after wake", pwr_state, 0);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      report();
   end

   initial begin
      step();
      t_reset();
      t_read_write();
      t_page();
      t_kinds();
      t_susp();
      t_wfi_pend();
      t_wfi_deep();
      t_halt_stop();
      t_prio();
      report();
   end
endmodule